// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address for every beat of one SDRAM read or write burst. A burst opens with a single-cycle `start` pulse, which carries the first column, the burst length and the order (sequential or interleaved). On each later enabled clock the block presents the next column of the burst. It raises `last` with the final address of a fixed-length burst.

Full-page bursts run through the whole page, wrapping from the top column to column 0, and continue until `stop` arrives. The `stop` input also cuts any burst short. When the clock-enable input `ce` is low, the block holds its position and its outputs, and it resumes on the next enabled clock. The address stream feeds a memory array or a data-path model. Row handling, bank selection and read latency are outside this block.

Top module: `sdram_col_seq`

## Requirements
- R1: During and right after reset, `valid` and `last` are 0 and `col` is 0. `col` also reads 0 whenever no burst is active.
- R2: A `start` pulse sampled with `ce` high makes `valid` 1 after that edge, and `col` then equals the start column.
- R3: Sequential order with lengths 2, 4 and 8 adds the beat number to the low log2(length) bits of the start column, wrapping inside that aligned block. The upper bits keep the start column's value.
- R4: Interleaved order with lengths 2, 4 and 8 gives beat n the address (start column XOR n).
- R5: `len_sel` values 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. `last` is 1 exactly with the final beat, and `valid` is 0 after the next enabled edge unless a new `start` arrives on that edge.
- R6: `len_sel` values 4 to 7 select a full page. The column then steps by one on each enabled edge, wraps from 255 to 0, never raises `last`, and runs until `stop`.
- R7: A full-page burst with interleaved order produces the same sequence as sequential order.
- R8: `stop` sampled with `ce` high, and without `start`, ends the burst. `valid` is 0 after that edge and no further addresses appear.
- R9: While `ce` is low, `col`, `valid` and `last` keep their values. `start` and `stop` are ignored in those cycles.
- R10: Length and order are captured at `start`. Changing `len_sel` or `interleave` during a burst has no effect on that burst.
- R11: A `start` during an active burst abandons that burst and begins the new one. When `start` and `stop` arrive together, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; low freezes the sequencer |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| len_sel | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| interleave | input | 1 | 1 selects interleaved order |
| stop | input | 1 | Terminate the current burst |
| col | output | 8 | Current column address, 0 when idle |
| valid | output | 1 | A burst beat is being presented |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Directed bursts cover several cases. Start columns in the middle of an aligned block show whether sequential wrapping stays inside the block or carries into the upper bits. Interleaved starts with odd low bits separate XOR ordering from addition. Full-page bursts near column 255, in both orders, expose a missing page wrap, a stray `last`, or interleave being applied to full pages. Random mixes of `start`, `stop`, `ce` and mid-burst changes to the configuration test priority, freezing and the capture of settings at `start`. These random runs are compared against a bench model that derives each address from the start column and the beat number.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W     = 8,
  parameter int LSEL_W    = 3,
  parameter int MAX_FIXED = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic              interleave,
  input  logic              stop,
  output logic [COL_W-1:0]  col,
  output logic              valid,
  output logic              last
);

  localparam logic [LSEL_W-1:0] FIXED_TOP = LSEL_W'(MAX_FIXED);

  logic              active;
  logic [COL_W-1:0]  base;
  logic [COL_W-1:0]  beat;
  logic [LSEL_W-1:0] sel_q;
  logic              il_q;

  logic              full;
  logic [COL_W-1:0]  mask;
  logic [COL_W-1:0]  seq_addr;
  logic [COL_W-1:0]  il_addr;
  logic [COL_W-1:0]  col_inc;

  assign full     = sel_q > FIXED_TOP;
  assign mask     = full ? '1 : ~({COL_W{1'b1}} << sel_q);
  assign seq_addr = (base & ~mask) | ((base + beat) & mask);
  assign il_addr  = base ^ (beat & mask);
  assign col      = active ? ((il_q && !full) ? il_addr : seq_addr) : '0;
  assign valid    = active;
  assign last     = active && !full && (beat == mask);
  assign col_inc  = col + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      beat   <= '0;
      sel_q  <= '0;
      il_q   <= 1'b0;
    end else if (ce) begin
      if (start) begin
        active <= 1'b1;
        base   <= start_col;
        beat   <= '0;
        sel_q  <= len_sel;
        il_q   <= interleave;
      end else if (stop || last) begin
        active <= 1'b0;
      end else if (active) begin
        beat <= beat + 1'b1;
      end
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (col == '0) && !last);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ce && start |=> valid && (col == $past(start_col)));

  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ce && last && !start |=> !valid);

  a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    valid && full && ce && !start && !stop |=> valid && (col == $past(col_inc)) && !last);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ce && stop && !start |=> !valid);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(col) && $stable(valid) && $stable(last));

endmodule

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, start = 1'b0, interleave = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic [7:0] col;
  logic       valid, last;

  int errs = 0, checks = 0;

  bit       m_act = 0;
  bit [7:0] m_base = 0, m_n = 0;
  bit [2:0] m_len = 0;
  bit       m_il = 0;

  always #5 clk = ~clk;

  sdram_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .start_col(start_col),
    .len_sel(len_sel), .interleave(interleave), .stop(stop),
    .col(col), .valid(valid), .last(last)
  );

  function automatic bit [7:0] ecol(bit [7:0] b, bit [7:0] n, bit [2:0] ln, bit il);
    bit [7:0] m;
    if (ln > 3) return b + n;
    m = 8'((1 << ln) - 1);
    if (il) return b ^ n;
    return (b & ~m) | ((b + n) & m);
  endfunction

  function automatic bit elast();
    return m_act && m_len <= 3 && m_n == 8'((1 << m_len) - 1);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    chk(tag, "valid", valid, m_act);
    chk(tag, "last", last, elast());
    chk(tag, "col", col, m_act ? ecol(m_base, m_n, m_len, m_il) : 0);
  endtask

  function automatic string mode_tag();
    if (!m_act) return "R5";
    if (m_len > 3) return m_il ? "R7" : "R6";
    return m_il ? "R4" : "R3";
  endfunction

  task automatic step(string tag, bit s, bit [7:0] sc, bit [2:0] ls, bit il, bit sp, bit c);
    bit was_last;
    @(negedge clk);
    check_out(tag == "" ? mode_tag() : tag);
    start = s; start_col = sc; len_sel = ls; interleave = il; stop = sp; ce = c;
    was_last = elast();
    if (c) begin
      if (s) begin
        m_act = 1; m_base = sc; m_n = 0; m_len = ls; m_il = il;
      end else if (sp || was_last) m_act = 0;
      else if (m_act) m_n = m_n + 1;
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); check_out("R1");
    @(negedge clk); check_out("R1");
    rst_n = 1'b1;
    // R3: length 8 sequential from mid-block
    step("R1", 1, 8'h2D, 3, 0, 0, 1);
    for (int i = 0; i < 9; i++) step(i == 0 ? "R2" : "R3", 0, 0, 0, 0, 0, 1);
    // R4: interleaved length 4
    step("R5", 1, 8'h12, 2, 1, 0, 1);
    for (int i = 0; i < 5; i++) step("R4", 0, 0, 0, 0, 0, 1);
    // R7: full page interleaved near top, then R8 stop
    step("R5", 1, 8'hFC, 4, 1, 0, 1);
    for (int i = 0; i < 8; i++) step("R7", 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0, 0, 1);
    // R6: full page sequential wrap 255->0
    step("R8", 1, 8'hFE, 7, 0, 0, 1);
    for (int i = 0; i < 5; i++) step("R6", 0, 0, 0, 0, 0, 1);
    // R9: ce low ignores start and stop
    step("R6", 1, 8'h40, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 1);
    // R10: config changes mid-burst, R11 restart and start beats stop
    step("R9", 1, 8'h33, 1, 0, 0, 1);
    step("R10", 0, 0, 7, 1, 0, 1);
    step("R10", 1, 8'h07, 0, 0, 1, 1);
    step("R11", 0, 0, 0, 0, 0, 1);
    step("R5", 0, 0, 0, 0, 0, 1);
    // random
    for (int i = 0; i < 3000; i++)
      step("", ($urandom % 10) == 0, 8'($urandom), 3'($urandom), 1'($urandom),
           ($urandom % 30) == 0, ($urandom % 100) < 85);
    step("", 0, 0, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule